// File: doc/BRIEF.md
# Burst Address Counter

This block generates the address for one port of a synchronous memory. On every rising clock edge it chooses the address that the access in that cycle uses. The choice is made among four sources: a forced zero, an address supplied from outside, the previously used address plus one, or the previously used address unchanged. The chosen value is also stored as the counter state for the next cycle.

Three active-low controls pick the source. They have a fixed priority: counter clear, then address strobe, then count enable, then hold. The address output is combinational from the present controls and the stored state. This means a freshly loaded or freshly cleared address is used in the same cycle, with no dead cycle. A synchronous active-high system reset clears the stored state at power-up. The counter covers the full address space and wraps from the top address back to zero. The memory array and data path sit outside this block and take `addr_o` as their address.

Top module: `burst_addr_counter`

## Requirements
- R1: While `cnt_clr_n` is 0, `addr_o` is 0 whatever `strobe_n` and `adv_n` are, and 0 is stored for the next cycle.
- R2: While `cnt_clr_n` is 1 and `strobe_n` is 0, `addr_o` equals `ext_addr` in that same cycle, and that value is stored.
- R3: `adv_n` has no effect whenever `strobe_n` or `cnt_clr_n` is 0: the output is the loaded address or zero, never that value plus one.
- R4: With `cnt_clr_n` = 1, `strobe_n` = 1 and `adv_n` = 0, `addr_o` is the address of the previous cycle plus one.
- R5: With all three controls at 1, `addr_o` repeats the address of the previous cycle, and `ext_addr` is ignored.
- R6: An advance from the top address (all ADDR_W bits 1) gives address 0.
- R7: A clear cycle is a normal access cycle at address 0, and an advance in the next cycle gives address 1.
- R8: A clock edge with `sys_rst` = 1 stores 0, so a hold cycle after the reset shows address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sys_rst | input | 1 | Synchronous active-high reset of the stored state |
| cnt_clr_n | input | 1 | Active-low counter clear (highest priority) |
| strobe_n | input | 1 | Active-low address strobe, loads `ext_addr` |
| adv_n | input | 1 | Active-low count enable, advances by one |
| ext_addr | input | ADDR_W | Externally supplied address |
| addr_o | output | ADDR_W | Address used by the access in this cycle |

## Verification
The address output is due in the same cycle as the controls that select it, because the choice is combinational. The bench therefore drives each vector on the falling edge and samples `addr_o` one nanosecond later, before the next rising edge. The stored state only becomes visible one rising edge later, through the hold or advance vector that follows. Each check of increment, hold, wrap and reset recovery is therefore placed in the cycle after the vector that set up the state it depends on.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // Source selected for the address of the current cycle.
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_INC  = 2'd2,
      SRC_HOLD = 2'd3
   } addr_src_e;

   localparam int unsigned MIN_ADDR_W = 1;
   localparam int unsigned MAX_ADDR_W = 32;

endpackage

// File: rtl/burst_addr_decode.sv
// Priority decode of the three active-low controls.
module burst_addr_decode
   import burst_addr_pkg::*;
(
   input  logic      clr_n,
   input  logic      strobe_n,
   input  logic      adv_n,
   output addr_src_e src
);

   always_comb begin
      if (!clr_n)
         src = SRC_ZERO;
      else if (!strobe_n)
         src = SRC_EXT;
      else if (!adv_n)
         src = SRC_INC;
      else
         src = SRC_HOLD;
   end

endmodule

// File: rtl/burst_addr_incr.sv
// Wrapping +1 of the stored address; SPLIT picks a two-segment carry form.
module burst_addr_incr #(
   parameter int unsigned ADDR_W = 15,
   parameter bit          SPLIT  = 1'b1
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt
);

   localparam int unsigned LO_W = ADDR_W / 2;
   localparam int unsigned HI_W = ADDR_W - LO_W;

   initial begin
      if (ADDR_W < burst_addr_pkg::MIN_ADDR_W || ADDR_W > burst_addr_pkg::MAX_ADDR_W)
         $display("burst_addr_incr: ADDR_W %0d out of range", ADDR_W);
   end

   generate
      if (SPLIT && ADDR_W >= 4) begin : g_split
         logic [LO_W-1:0] lo_cur;
         logic [HI_W-1:0] hi_cur;
         logic            lo_full;
         assign lo_cur  = cur[LO_W-1:0];
         assign hi_cur  = cur[ADDR_W-1:LO_W];
         assign lo_full = &lo_cur;
         assign nxt[LO_W-1:0]      = lo_cur + LO_W'(1);
         assign nxt[ADDR_W-1:LO_W] = lo_full ? hi_cur + HI_W'(1) : hi_cur;
      end else begin : g_flat
         assign nxt = cur + ADDR_W'(1);
      end
   endgenerate

endmodule

// File: rtl/burst_addr_state.sv
// Stored counter state with synchronous system reset.
module burst_addr_state #(
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              sys_rst,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (sys_rst)
         q <= '0;
      else
         q <= d;
   end

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter bit          SPLIT_INC = 1'b1
) (
   input  logic              clk,
   input  logic              sys_rst,
   input  logic              cnt_clr_n,
   input  logic              strobe_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] addr_o
);

   initial begin
      if (ADDR_W < MIN_ADDR_W || ADDR_W > MAX_ADDR_W)
         $display("burst_addr_counter: ADDR_W %0d out of range", ADDR_W);
   end

   addr_src_e         src;
   logic [ADDR_W-1:0] state_q;
   logic [ADDR_W-1:0] state_inc;
   logic [ADDR_W-1:0] chosen;

   burst_addr_decode u_dec (
      .clr_n    (cnt_clr_n),
      .strobe_n (strobe_n),
      .adv_n    (adv_n),
      .src      (src)
   );

   burst_addr_incr #(.ADDR_W(ADDR_W), .SPLIT(SPLIT_INC)) u_inc (
      .cur (state_q),
      .nxt (state_inc)
   );

   always_comb begin
      unique case (src)
         SRC_ZERO: chosen = '0;
         SRC_EXT:  chosen = ext_addr;
         SRC_INC:  chosen = state_inc;
         default:  chosen = state_q;
      endcase
   end

   burst_addr_state #(.ADDR_W(ADDR_W)) u_state (
      .clk     (clk),
      .sys_rst (sys_rst),
      .d       (chosen),
      .q       (state_q)
   );

   assign addr_o = chosen;

endmodule

// File: rtl/burst_addr_counter_chk.sv
module burst_addr_counter_chk #(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              sys_rst,
   input logic              cnt_clr_n,
   input logic              strobe_n,
   input logic              adv_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [ADDR_W-1:0] addr_o
);

   logic adv_cyc;
   assign adv_cyc = cnt_clr_n && strobe_n && !adv_n;

   a_r1_clear_zero: assert property (@(posedge clk) disable iff (sys_rst)
      !cnt_clr_n |-> addr_o == '0);

   a_r2_strobe_load: assert property (@(posedge clk) disable iff (sys_rst)
      (cnt_clr_n && !strobe_n) |-> addr_o == ext_addr);

   a_r4_advance: assert property (@(posedge clk) disable iff (sys_rst)
      (adv_cyc && !$past(sys_rst) && !(&$past(addr_o))) |-> addr_o == $past(addr_o) + ADDR_W'(1));

   a_r5_hold: assert property (@(posedge clk) disable iff (sys_rst)
      (cnt_clr_n && strobe_n && adv_n && !$past(sys_rst)) |-> addr_o == $past(addr_o));

   a_r6_wrap: assert property (@(posedge clk) disable iff (sys_rst)
      (adv_cyc && !$past(sys_rst) && (&$past(addr_o))) |-> addr_o == '0);

   a_r7_after_clear: assert property (@(posedge clk) disable iff (sys_rst)
      (adv_cyc && !$past(sys_rst) && !$past(cnt_clr_n)) |-> addr_o == ADDR_W'(1));

   a_r8_after_sysrst: assert property (@(posedge clk) disable iff (sys_rst)
      (cnt_clr_n && strobe_n && adv_n && $past(sys_rst)) |-> addr_o == '0);

endmodule

bind burst_addr_counter burst_addr_counter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .sys_rst   (sys_rst),
   .cnt_clr_n (cnt_clr_n),
   .strobe_n  (strobe_n),
   .adv_n     (adv_n),
   .ext_addr  (ext_addr),
   .addr_o    (addr_o)
);

// File: tb/tb_burst_addr_counter.sv
`timescale 1ns/1ps
module tb_burst_addr_counter;

   localparam int unsigned AW = 15;

   logic          clk = 1'b0;
   logic          sys_rst = 1'b1;
   logic          cnt_clr_n = 1'b1;
   logic          strobe_n = 1'b1;
   logic          adv_n = 1'b1;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] addr_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   burst_addr_counter #(.ADDR_W(AW)) dut (
      .clk(clk), .sys_rst(sys_rst), .cnt_clr_n(cnt_clr_n),
      .strobe_n(strobe_n), .adv_n(adv_n), .ext_addr(ext_addr), .addr_o(addr_o)
   );

   typedef struct packed {
      logic          clr_n;
      logic          stb_n;
      logic          adv_n;
      logic [AW-1:0] ext;
      logic [AW-1:0] exp;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 1'b1, 15'h1234, 15'h0000, 4'd8}, // R8 hold after system reset
      '{1'b1, 1'b0, 1'b1, 15'h0100, 15'h0100, 4'd2}, // R2 load
      '{1'b1, 1'b1, 1'b0, 15'h7777, 15'h0101, 4'd4}, // R4 advance
      '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0102, 4'd4}, // R4 advance
      '{1'b1, 1'b1, 1'b1, 15'h5555, 15'h0102, 4'd5}, // R5 hold, ext ignored
      '{1'b1, 1'b0, 1'b0, 15'h0200, 15'h0200, 4'd3}, // R3 enable ignored under strobe
      '{1'b0, 1'b0, 1'b0, 15'h0300, 15'h0000, 4'd1}, // R1 clear beats strobe/enable
      '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0001, 4'd7}, // R7 advance after clear
      '{1'b0, 1'b1, 1'b1, 15'h1111, 15'h0000, 4'd1}, // R1 clear alone
      '{1'b1, 1'b0, 1'b1, 15'h7FFE, 15'h7FFE, 4'd2}, // R2 load near top
      '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h7FFF, 4'd4}, // R4 to top
      '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0000, 4'd6}, // R6 wrap
      '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0001, 4'd6}, // R6 continues after wrap
      '{1'b0, 1'b0, 1'b1, 15'h2222, 15'h0000, 4'd1}  // R1 clear beats strobe
   };

   task automatic check(input logic [AW-1:0] exp, input string tag);
      checks++;
      if (addr_o !== exp) begin
         errors++;
         $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp);
      end
   endtask

   task automatic apply(input logic c, input logic s, input logic a, input logic [AW-1:0] e);
      @(negedge clk);
      cnt_clr_n = c; strobe_n = s; adv_n = a; ext_addr = e;
      #1;
   endtask

   initial begin : watchdog
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      sys_rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].clr_n, VECS[i].stb_n, VECS[i].adv_n, VECS[i].ext);
         check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end

      // R5: ext changes on consecutive hold cycles have no effect
      apply(1'b1, 1'b0, 1'b1, 15'h0ABC);
      check(15'h0ABC, "R2 load before hold run");
      for (int k = 0; k < 4; k++) begin
         apply(1'b1, 1'b1, 1'b1, AW'(15'h1000 + k * 15'h0111));
         check(15'h0ABC, "R5 hold with changing ext");
      end

      // R3: enable ignored under clear, then advance proves stored zero
      apply(1'b0, 1'b1, 1'b0, 15'h3333);
      check(15'h0000, "R3 enable ignored under clear");
      apply(1'b1, 1'b1, 1'b0, 15'h3333);
      check(15'h0001, "R7 advance right after clear");

      // R8: system reset mid-run clears stored state
      apply(1'b1, 1'b0, 1'b1, 15'h4444);
      check(15'h4444, "R2 load before system reset");
      @(negedge clk);
      sys_rst = 1'b1;
      strobe_n = 1'b1;
      @(negedge clk);
      sys_rst = 1'b0;
      #1;
      check(15'h0000, "R8 hold after system reset");
      apply(1'b1, 1'b1, 1'b0, 15'h4444);
      check(15'h0001, "R8 advance from cleared state");

      // R6: wrap from top via load of all ones
      apply(1'b1, 1'b0, 1'b1, 15'h7FFF);
      check(15'h7FFF, "R2 load top address");
      apply(1'b1, 1'b1, 1'b0, 15'h0000);
      check(15'h0000, "R6 wrap from loaded top");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule